// File: doc/BRIEF.md
# Lane-Parallel Fractional Vector Multiplier

This unit multiplies two 128-bit vectors lane by lane, treating every lane as a signed fraction in [-1, 1). A format select splits the vector into eight 16-bit lanes with 15 fraction bits, or into four 32-bit lanes with 31 fraction bits. The double-width product of each lane pair is scaled back to the lane's fraction position and clamped to the lane range. The result can be the scaled product alone, a third vector plus the product, or a third vector minus the product. Each of these has a truncating variant and a rounding variant.

An operation is offered by holding the operands, format and operation code for one cycle with `in_valid` high. The unit has two pipeline registers and no stall path, so a new operation may be offered every cycle. Each accepted operation gives exactly one `out_valid` pulse, a fixed number of cycles later. Between pulses the result output keeps its last value.

Top module: `qvec_mul`

## Requirements
- R1: An operation sampled with `in_valid` high at a rising edge yields `out_valid` high, with its result, after the next rising edge, for exactly one cycle. Operations offered on consecutive cycles give results on consecutive cycles, in the same order.
- R2: Lane n occupies result and operand bits [n*W+W-1 : n*W], with lane 0 at bit 0. No lane's result depends on any other lane.
- R3: `fmt` = 0 selects eight 16-bit lanes (W=16, F=15). `fmt` = 1 selects four 32-bit lanes (W=32, F=31).
- R4: `op[0]` = 1 selects rounding. `op[2:1]` selects the kind: 00 = multiply, 01 = multiply-add, 10 = multiply-subtract, 11 = multiply (same as 00).
- R5: Truncating multiply gives floor(a*b / 2^F), which rounds toward minus infinity, clamped to [-2^(W-1), 2^(W-1)-1].
- R6: The rounding variant of every kind adds 2^(F-1) to the full-precision value before it is divided by 2^F.
- R7: A lane with both inputs at the most negative value gives the largest positive value (0x7FFF or 0x7FFFFFFF) for a multiply.
- R8: Multiply-add gives floor((c*2^F + a*b + rnd) / 2^F). The sum is computed without loss and is then clamped to the lane range in both directions.
- R9: Multiply-subtract gives floor((c*2^F - a*b + rnd) / 2^F). It is computed without loss and is then clamped in both directions.
- R10: While `rst_n` is sampled low, and after it is released, `out_valid` is 0 and `result` is all zeros until the first result arrives.
- R11: When `out_valid` is low, `result` holds the value of the most recent result, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| fmt | input | 1 | Lane format: 0 = 16-bit lanes, 1 = 32-bit lanes |
| op | input | 3 | Rounding bit [0] and operation kind [2:1] |
| vec_a | input | 128 | Multiplicand vector |
| vec_b | input | 128 | Multiplier vector |
| vec_c | input | 128 | Accumulator vector for add and subtract |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Scaled, clamped lane results |

## Verification
A corrupted product or accumulator register in a lane shows up in that lane's field only, at the `out_valid` pulse for the operation that used it. That is two edges after the strobe, and the value is off either by a fraction bit or by a missed clamp. A wrong format or valid bit in the control pipeline is wider in effect. The whole vector then reads from the wrong lane group, or `out_valid` appears on the wrong cycle, and a burst of back-to-back operations exposes this at once through missing, shifted or extra pulses. Stale data leaking into an idle cycle shows as `result` changing while `out_valid` is low.

// File: rtl/qvm_pkg.sv
// Shared types and constants of the fractional vector multiplier.
// Assumes: the vector width is fixed at 128 bits; the lane counts follow from it.
package qvm_pkg;

    localparam int VEC_W   = 128;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 32;
    localparam int HALF_N  = VEC_W / HALF_W;
    localparam int WORD_N  = VEC_W / WORD_W;

    // Operation kind, taken from op[2:1]; KIND_MULX behaves as KIND_MUL
    typedef enum logic [1:0] {
        KIND_MUL  = 2'b00,
        KIND_ADD  = 2'b01,
        KIND_SUB  = 2'b10,
        KIND_MULX = 2'b11
    } acc_kind_e;

endpackage

// File: rtl/qvm_ctrl.sv
// Control pipeline: carries the valid strobe and the lane format alongside
// the two lane register stages, and produces the load enables for each stage.
// Assumes: no back-pressure, so every accepted strobe leaves two cycles later.
module qvm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic fmt,
    output logic ld1_half,
    output logic ld1_word,
    output logic ld2_half,
    output logic ld2_word,
    output logic out_valid,
    output logic fmt_out
);

    logic v1_q, v2_q, fmt1_q, fmt2_q;
    logic [1:0] age_q;

    // Stage enables, gated by format so the idle lane group keeps its state
    assign ld1_half  = in_valid & ~fmt;
    assign ld1_word  = in_valid &  fmt;
    assign ld2_half  = v1_q & ~fmt1_q;
    assign ld2_word  = v1_q &  fmt1_q;
    assign out_valid = v2_q;
    assign fmt_out   = fmt2_q;

    // Valid and format shift through two stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q   <= 1'b0;
            v2_q   <= 1'b0;
            fmt1_q <= 1'b0;
            fmt2_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
            v2_q <= v1_q;
            if (in_valid) fmt1_q <= fmt;
            if (v1_q)     fmt2_q <= fmt1_q;
        end
    end

    // Cycles since reset, saturating at two, so the check below never looks before reset
    always_ff @(posedge clk) begin
        if (!rst_n)          age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assert_fixed_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_idle_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> !out_valid);

endmodule

// File: rtl/qvm_lane.sv
// One fractional lane of width W with F = W-1 fraction bits.
// Stage 1 registers the full product and the accumulator operand; stage 2
// aligns the accumulator, adds or subtracts, rounds, shifts right by F and
// clamps to the lane range. Assumes: load_s2 follows load_s1 by one cycle.
module qvm_lane
    import qvm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_s1,
    input  logic         load_s2,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  acc_kind_e    kind,
    input  logic         rnd,
    output logic [W-1:0] res
);

    localparam int F  = W - 1;
    localparam int PW = 2 * W + 2;
    localparam int SW = PW - F;
    localparam logic signed [SW-1:0] SAT_HI = $signed({{4{1'b0}}, {(W-1){1'b1}}});
    localparam logic signed [SW-1:0] SAT_LO = $signed({{4{1'b1}}, {(W-1){1'b0}}});
    localparam logic signed [PW-1:0] RND_C  = $signed({{(PW-F){1'b0}}, 1'b1, {(F-1){1'b0}}});
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic signed [2*W-1:0] a_x, b_x, prod_q;
    logic [W-1:0]          c_q;
    acc_kind_e             kind_q;
    logic                  rnd_q;
    logic signed [PW-1:0]  p_ext, c_ext, acc;
    logic signed [SW-1:0]  shifted;
    logic [W-1:0]          res_d;

    // Sign-extend the operands so the product is exact at 2W bits
    assign a_x = $signed({{W{a[W-1]}}, a});
    assign b_x = $signed({{W{b[W-1]}}, b});

    // Stage 1: capture the exact product and the accumulator operand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            c_q    <= '0;
            kind_q <= KIND_MUL;
            rnd_q  <= 1'b0;
        end else if (load_s1) begin
            prod_q <= a_x * b_x;
            c_q    <= c;
            kind_q <= kind;
            rnd_q  <= rnd;
        end
    end

    // Align the product and the accumulator (scaled by 2^F) in a common wide format
    assign p_ext = $signed({{2{prod_q[2*W-1]}}, prod_q});
    assign c_ext = $signed({{3{c_q[W-1]}}, c_q, {F{1'b0}}});

    // Combine at full precision and add the rounding half-LSB if requested
    always_comb begin
        unique case (kind_q)
            KIND_ADD: acc = c_ext + p_ext;
            KIND_SUB: acc = c_ext - p_ext;
            default:  acc = p_ext;
        endcase
        if (rnd_q) acc = acc + RND_C;
    end

    // Rescale to the lane fraction position and clamp to the lane range
    always_comb begin
        shifted = acc[PW-1:F];
        if (shifted > SAT_HI)      res_d = MOST_POS;
        else if (shifted < SAT_LO) res_d = MOST_NEG;
        else                       res_d = shifted[W-1:0];
    end

    // Stage 2: register the lane result
    always_ff @(posedge clk) begin
        if (!rst_n)       res <= '0;
        else if (load_s2) res <= res_d;
    end

    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_s2 |=> $stable(res));

    assert_neg_square_clamps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s1 && a == MOST_NEG && b == MOST_NEG && kind[1] == kind[0])
        |=> ##1 (res == MOST_POS));

    assert_zero_factor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s1 && a == '0 && kind[1] == kind[0]) |=> ##1 (res == '0));

    assert_stage_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_s1 |=> load_s2);

endmodule

// File: rtl/qvec_mul.sv
// Top of the lane-parallel fractional vector multiplier. It holds one group of
// 16-bit lanes and one group of 32-bit lanes, and the format picks which group
// is loaded and which group drives the result.
// Assumes: inputs are sampled only on cycles with in_valid high.
module qvec_mul
    import qvm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         fmt,
    input  logic [2:0]   op,
    input  logic [127:0] vec_a,
    input  logic [127:0] vec_b,
    input  logic [127:0] vec_c,
    output logic         out_valid,
    output logic [127:0] result
);

    logic ld1_half, ld1_word, ld2_half, ld2_word, fmt_out;
    logic [VEC_W-1:0] res_half, res_word;
    acc_kind_e kind;

    assign kind = acc_kind_e'(op[2:1]);

    qvm_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .fmt      (fmt),
        .ld1_half (ld1_half),
        .ld1_word (ld1_word),
        .ld2_half (ld2_half),
        .ld2_word (ld2_word),
        .out_valid(out_valid),
        .fmt_out  (fmt_out)
    );

    for (genvar n = 0; n < HALF_N; n++) begin : g_half
        qvm_lane #(.W(HALF_W)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_s1(ld1_half),
            .load_s2(ld2_half),
            .a      (vec_a[n*HALF_W +: HALF_W]),
            .b      (vec_b[n*HALF_W +: HALF_W]),
            .c      (vec_c[n*HALF_W +: HALF_W]),
            .kind   (kind),
            .rnd    (op[0]),
            .res    (res_half[n*HALF_W +: HALF_W])
        );
    end

    for (genvar n = 0; n < WORD_N; n++) begin : g_word
        qvm_lane #(.W(WORD_W)) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_s1(ld1_word),
            .load_s2(ld2_word),
            .a      (vec_a[n*WORD_W +: WORD_W]),
            .b      (vec_b[n*WORD_W +: WORD_W]),
            .c      (vec_c[n*WORD_W +: WORD_W]),
            .kind   (kind),
            .rnd    (op[0]),
            .res    (res_word[n*WORD_W +: WORD_W])
        );
    end

    // Result comes from the lane group that produced the latest output
    assign result = fmt_out ? res_word : res_half;

    assert_hold_between_pulses_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(result) or $past(!rst_n));

endmodule

// File: tb/qvec_mul_tb.sv
// Directed bench: one task per scenario, expected values from a lane model
// written from the requirements.
module qvec_mul_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         fmt = 1'b0;
    logic [2:0]   op = 3'd0;
    logic [127:0] vec_a = '0, vec_b = '0, vec_c = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qvec_mul dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt(fmt), .op(op),
        .vec_a(vec_a), .vec_b(vec_b), .vec_c(vec_c),
        .out_valid(out_valid), .result(result)
    );

    localparam logic [127:0] HA = {16'h4000, 16'h8000, 16'hFFFF, 16'h7FFF,
                                   16'h0001, 16'hC000, 16'h1234, 16'h8000};
    localparam logic [127:0] HB = {16'h4000, 16'h8000, 16'h4000, 16'h7FFF,
                                   16'h7FFF, 16'h4000, 16'hEDCC, 16'h7FFF};
    localparam logic [127:0] HC = {16'h7FFF, 16'h8000, 16'h0003, 16'h7000,
                                   16'h8001, 16'h0000, 16'h1000, 16'h8000};
    localparam logic [127:0] WA = {32'h80000000, 32'h40000000, 32'hFFFFFFFF, 32'h7FFFFFFF};
    localparam logic [127:0] WB = {32'h80000000, 32'h40000000, 32'h40000000, 32'h80000001};
    localparam logic [127:0] WC = {32'h7FFFFFFF, 32'h80000000, 32'h00000001, 32'hC0000000};

    // One lane: exact arithmetic, then shift by F and clamp
    function automatic logic [31:0] lane_model(input int w, input logic [2:0] o,
            input logic signed [79:0] x, input logic signed [79:0] y,
            input logic signed [79:0] z);
        int f = w - 1;
        logic signed [79:0] p, acc, q, hi, lo;
        p = x * y;
        case (o[2:1])
            2'b01:   acc = (z <<< f) + p;
            2'b10:   acc = (z <<< f) - p;
            default: acc = p;
        endcase
        if (o[0]) acc = acc + (80'sd1 <<< (f - 1));
        q  = acc >>> f;
        hi = (80'sd1 <<< (w - 1)) - 80'sd1;
        lo = -(80'sd1 <<< (w - 1));
        if (q > hi) q = hi;
        if (q < lo) q = lo;
        return q[31:0];
    endfunction

    function automatic logic [127:0] model(input logic f32, input logic [2:0] o,
            input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
        logic [127:0] r = '0;
        logic signed [79:0] x, y, z;
        logic [31:0] t;
        if (f32) begin
            for (int n = 0; n < 4; n++) begin
                x = $signed(a[n*32 +: 32]); y = $signed(b[n*32 +: 32]); z = $signed(c[n*32 +: 32]);
                t = lane_model(32, o, x, y, z);
                r[n*32 +: 32] = t;
            end
        end else begin
            for (int n = 0; n < 8; n++) begin
                x = $signed(a[n*16 +: 16]); y = $signed(b[n*16 +: 16]); z = $signed(c[n*16 +: 16]);
                t = lane_model(16, o, x, y, z);
                r[n*16 +: 16] = t[15:0];
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Offer one operation at a falling edge and sample its result two rising edges later
    task automatic run_one(input string req, input logic f, input logic [2:0] o,
            input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
            output logic [127:0] got);
        fmt = f; op = o; vec_a = a; vec_b = b; vec_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        vec_a = ~a; vec_b = ~b;
        @(negedge clk);
        check({req, " out_valid"}, {127'd0, out_valid}, 128'd1);
        got = result;
        check(req, got, model(f, o, a, b, c));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; vec_a = HA; vec_b = HB;
        repeat (3) @(negedge clk);
        check("R10 out_valid in reset", {127'd0, out_valid}, 128'd0);
        check("R10 result in reset", result, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 out_valid after release", {127'd0, out_valid}, 128'd0);
        check("R10 result after release", result, '0);
    endtask

    task automatic t_half_mul();
        logic [127:0] g;
        run_one("R5 q15 truncating multiply", 1'b0, 3'b000, HA, HB, HC, g);
        check("R7 q15 most-negative square", {112'd0, g[111:96]}, 128'h7FFF);
        check("R5 q15 floor of negative", {112'd0, g[95:80]}, 128'hFFFF);
        run_one("R6 q15 rounding multiply", 1'b0, 3'b001, HA, HB, HC, g);
        check("R6 q15 rounded half-LSB", {112'd0, g[95:80]}, 128'h0000);
    endtask

    task automatic t_layout();
        logic [127:0] g;
        run_one("R2 single lane", 1'b0, 3'b000, 128'h4000 << 48, 128'h4000 << 48, '0, g);
        check("R2 lane 3 position", g, 128'h2000 << 48);
    endtask

    task automatic t_half_acc();
        logic [127:0] g;
        run_one("R8 q15 multiply-add", 1'b0, 3'b010, HA, HB, HC, g);
        check("R8 q15 clamp high", {112'd0, g[127:112]}, 128'h7FFF);
        run_one("R8 q15 multiply-add rounding", 1'b0, 3'b011, HA, HB, HC, g);
        run_one("R9 q15 multiply-subtract", 1'b0, 3'b100, HA, HB, HC, g);
        check("R9 q15 clamp low", {112'd0, g[111:96]}, 128'h8000);
        run_one("R9 q15 multiply-subtract rounding", 1'b0, 3'b101, HA, HB, HC, g);
    endtask

    task automatic t_word();
        logic [127:0] g;
        run_one("R3 q31 truncating multiply", 1'b1, 3'b000, WA, WB, WC, g);
        check("R7 q31 most-negative square", {96'd0, g[127:96]}, 128'h7FFFFFFF);
        run_one("R6 q31 rounding multiply", 1'b1, 3'b001, WA, WB, WC, g);
        run_one("R8 q31 multiply-add", 1'b1, 3'b011, WA, WB, WC, g);
        run_one("R9 q31 multiply-subtract", 1'b1, 3'b100, WA, WB, WC, g);
    endtask

    task automatic t_kind11();
        logic [127:0] g;
        run_one("R4 kind 11 as multiply", 1'b0, 3'b110, HA, HB, HC, g);
        check("R4 kind 11 equals kind 00", g, model(1'b0, 3'b000, HA, HB, HC));
        run_one("R4 kind 11 rounding", 1'b1, 3'b111, WA, WB, WC, g);
    endtask

    // Three operations back to back, mixed formats, results in order on consecutive cycles
    task automatic t_burst();
        logic [127:0] exp0, exp1, exp2;
        exp0 = model(1'b0, 3'b010, HA, HB, HC);
        exp1 = model(1'b1, 3'b100, WA, WB, WC);
        exp2 = model(1'b0, 3'b001, HB, HA, HC);
        fmt = 1'b0; op = 3'b010; vec_a = HA; vec_b = HB; vec_c = HC; in_valid = 1'b1;
        @(negedge clk);
        fmt = 1'b1; op = 3'b100; vec_a = WA; vec_b = WB; vec_c = WC;
        @(negedge clk);
        check("R1 burst first valid", {127'd0, out_valid}, 128'd1);
        check("R1 burst first result", result, exp0);
        fmt = 1'b0; op = 3'b001; vec_a = HB; vec_b = HA; vec_c = HC;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 burst second valid", {127'd0, out_valid}, 128'd1);
        check("R1 burst second result", result, exp1);
        @(negedge clk);
        check("R1 burst third valid", {127'd0, out_valid}, 128'd1);
        check("R1 burst third result", result, exp2);
        @(negedge clk);
        check("R1 single pulse per strobe", {127'd0, out_valid}, 128'd0);
    endtask

    // Inputs toggle with no strobe; the result must not move
    task automatic t_hold();
        logic [127:0] g;
        run_one("R11 setup", 1'b1, 3'b010, WA, WB, WC, g);
        for (int i = 0; i < 5; i++) begin
            fmt = i[0]; op = 3'(i); vec_a = {4{32'(i * 7919)}}; vec_b = ~vec_a; vec_c = vec_a ^ HC;
            @(negedge clk);
            check("R11 no pulse while idle", {127'd0, out_valid}, 128'd0);
            check("R11 result held while idle", result, g);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_half_mul();
        t_layout();
        t_half_acc();
        t_word();
        t_kind11();
        t_burst();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule